// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a three-level page table in memory. A translation request carries the address, a privilege mode (kernel or user) and the kind of access needed. The walker first checks that the address is sign-extended correctly. It then looks for a direct-mapped kernel window. If the address falls in neither case, it fetches one 8-byte table entry per level through a 64-bit read port. The result is a physical address with the read, write and execute permissions that remain, or a fault code together with the faulting address and the access type.

Permissions are granted in two stages. First, the leaf entry's enable bits for the current mode grant access. Then the leaf entry's fault-on-read, fault-on-write and fault-on-execute bits can take back an access that was granted. Both inbound interfaces use valid/ready. A request is accepted only when `req_valid` and `req_ready` are both high on a rising edge, and `req_ready` is high only while the walker is idle. A memory read is issued by holding `mem_req_valid` high with a fixed `mem_req_addr` until `mem_req_ready` is seen. The memory side applies back-pressure by holding `mem_req_ready` low. Exactly one response beat, flagged by `mem_rsp_valid`, must follow each accepted read. There is only ever one outstanding read. The result is given by a one-cycle `done` pulse.

Top module: `ptw_walker`

## Requirements
- R1: If any of bits 63 down to VA_BITS (default 43) of the address differs from bit 63, the request ends with fault code 1 (access violation) and no memory read is made.
- R2: A superpage is a canonical address with bit 63 set and bits [VA_BITS-1:VA_BITS-2] equal to 2'b10. In kernel mode it succeeds with pa = VA[39:0], all three permissions set, and no memory read. In user mode it gives fault code 1, also with no memory read.
- R3: A walk makes three reads. Each read address is the table base plus 8 times a 10-bit index. The first base is `ptbr`. The indexes are VA[PAGE_BITS+29:PAGE_BITS+20], VA[PAGE_BITS+19:PAGE_BITS+10] and VA[PAGE_BITS+9:PAGE_BITS], with PAGE_BITS defaulting to 13. Each following base is the entry's bits [63:32] shifted left by PAGE_BITS.
- R4: At level 1 or 2, an entry with bit 0 (valid) clear gives fault code 0 (not valid). An entry with bit 8 (kernel read enable) clear gives fault code 1. In both cases the walk stops and no further reads are made.
- R5: A level-3 entry with bit 0 clear gives fault code 0.
- R6: On the leaf, the read-enable bit (bit 8 in kernel mode, bit 9 in user mode) grants read and execute. The write-enable bit (bit 12 in kernel mode, bit 13 in user mode) grants write. The access type is encoded on `req_acc` as 0 read, 1 write, 2 execute and 3 probe. A read, write or execute that is not granted gives fault code 1.
- R7: Leaf bits 1, 2 and 3 remove granted read, write and execute. If the needed access is removed, the fault is code 3 for execute, code 4 for write and code 2 for read, checked in that priority. On success, `perm_r`/`perm_w`/`perm_x` report the permissions left after this removal.
- R8: On a walk that succeeds, pa = {leaf[63:32], VA[PAGE_BITS-1:0]}.
- R9: A probe (`req_acc`=3) needs no access. It is never refused by the enable or fault-on bits, and returns the remaining permissions, which may all be zero.
- R10: On a fault, `fault_va` holds the request address. `fault_acc` holds 2'b00 for read, 2'b01 for write, 2'b11 for execute and 2'b10 for probe.
- R11: `req_ready` is high only while idle. A memory request held under back-pressure keeps its address. `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken on this edge |
| req_va | input | 64 | Virtual address |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| req_acc | input | 2 | Access needed: 0 read, 1 write, 2 execute, 3 probe |
| ptbr | input | PA_W (45) | Byte address of the level-1 table |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W (45) | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data beat present |
| mem_rsp_data | input | 64 | Table entry |
| done | output | 1 | One-cycle result pulse |
| ok | output | 1 | Result is a translation (1) or a fault (0) |
| fault_code | output | 3 | 0 not valid, 1 access violation, 2 read, 3 execute, 4 write |
| pa | output | PA_W (45) | Physical address on success |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |
| fault_va | output | 64 | Faulting virtual address |
| fault_acc | output | 2 | Access-type code of the fault |

## Verification
The assertions check these properties on every cycle:
- a memory request held under back-pressure keeps its address;
- `done` lasts one cycle, and no new request is accepted while a read is pending;
- the number of reads never exceeds three;
- a successful read, write or execute reports the permission it needed;
- each fault-on code matches the access type of the captured request;
- a probe never ends in a fault-on code;
- a superpage success returns the low 40 address bits with no read.

Only the bench scenarios can show the following:
- the exact entry addresses produced from the index fields and the chained bases;
- where a walk stops for each invalid or unreadable directory entry;
- the priority between access violation and fault-on results;
- which permissions survive the masking for each mode.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    FLT_TNV = 3'd0,
    FLT_ACV = 3'd1,
    FLT_FOR = 3'd2,
    FLT_FOE = 3'd3,
    FLT_FOW = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD    = 2'd0,
    ACC_WR    = 2'd1,
    ACC_EX    = 2'd2,
    ACC_PROBE = 2'd3
  } acc_e;

  // Entry bit positions (the table format in memory depends on these)
  localparam int B_VALID = 0;
  localparam int B_FO_RD = 1;
  localparam int B_FO_WR = 2;
  localparam int B_FO_EX = 3;
  localparam int B_KRD   = 8;
  localparam int B_URD   = 9;
  localparam int B_KWR   = 12;
  localparam int B_UWR   = 13;

  function automatic logic [1:0] acc_report(input logic [1:0] a);
    case (a)
      ACC_RD:  return 2'b00;
      ACC_WR:  return 2'b01;
      ACC_EX:  return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/ptw_va_decode.sv
module ptw_va_decode #(
  parameter int VA_BITS = 43
) (
  input  logic [63:0] va,
  output logic        canon,
  output logic        super_hit
);
  localparam int HI_W = 64 - VA_BITS;

  // Upper bits must all copy the sign bit
  assign canon     = (va[63:VA_BITS] == {HI_W{va[63]}});
  assign super_hit = va[63] & (va[VA_BITS-1:VA_BITS-2] == 2'b10);
endmodule

// File: rtl/ptw_dir_check.sv
module ptw_dir_check
  import ptw_pkg::*;
#(
  parameter int PAGE_BITS = 13,
  parameter int PA_W      = 32 + PAGE_BITS
) (
  input  logic [63:0]     pte,
  output logic            is_valid,
  output logic            kread_ok,
  output logic [PA_W-1:0] next_base
);
  logic unused_dir_bits;

  assign is_valid  = pte[B_VALID];
  assign kread_ok  = pte[B_KRD];
  assign next_base = PA_W'({pte[63:32], {PAGE_BITS{1'b0}}});
  assign unused_dir_bits = ^{pte[31:B_KRD+1], pte[B_KRD-1:B_VALID+1]};
endmodule

// File: rtl/ptw_leaf_perm.sv
module ptw_leaf_perm
  import ptw_pkg::*;
(
  input  logic [63:0] pte,
  input  logic        user,
  input  logic [1:0]  acc,
  output logic        fault,
  output logic [2:0]  code,
  output logic        pr,
  output logic        pw,
  output logic        px
);
  logic rd_en, wr_en, need_r, need_w, need_x, any_need, granted, kept;
  logic unused_leaf_bits;

  assign rd_en = user ? pte[B_URD] : pte[B_KRD];
  assign wr_en = user ? pte[B_UWR] : pte[B_KWR];

  assign need_r   = (acc == ACC_RD);
  assign need_w   = (acc == ACC_WR);
  assign need_x   = (acc == ACC_EX);
  assign any_need = need_r | need_w | need_x;

  // Stage one: mode enables
  assign granted = (need_r & rd_en) | (need_w & wr_en) | (need_x & rd_en);

  // Stage two: fault-on bits withdraw what was granted
  assign pr = rd_en & ~pte[B_FO_RD];
  assign pw = wr_en & ~pte[B_FO_WR];
  assign px = rd_en & ~pte[B_FO_EX];
  assign kept = (need_r & pr) | (need_w & pw) | (need_x & px);

  always_comb begin
    fault = 1'b1;
    code  = FLT_TNV;
    if (!pte[B_VALID])           code = FLT_TNV;
    else if (any_need && !granted) code = FLT_ACV;
    else if (any_need && !kept) begin
      if (need_x)      code = FLT_FOE;
      else if (need_w) code = FLT_FOW;
      else             code = FLT_FOR;
    end else begin
      fault = 1'b0;
      code  = FLT_TNV;
    end
  end

  assign unused_leaf_bits = ^{pte[63:B_UWR+1], pte[B_KWR-1:B_URD+1], pte[B_KRD-1:B_FO_EX+1]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = 10,
  parameter int SP_BITS   = 40,
  parameter int PA_W      = 32 + PAGE_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_va,
  input  logic            req_user,
  input  logic [1:0]      req_acc,
  input  logic [PA_W-1:0] ptbr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            done,
  output logic            ok,
  output logic [2:0]      fault_code,
  output logic [PA_W-1:0] pa,
  output logic            perm_r,
  output logic            perm_w,
  output logic            perm_x,
  output logic [63:0]     fault_va,
  output logic [1:0]      fault_acc
);
  localparam logic [1:0] LVL_LEAF = 2'd2;
  localparam int         PAD_W    = PA_W - IDX_W - 3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} state_e;

  state_e          st_q;
  logic [1:0]      lvl_q;
  logic [63:0]     va_q;
  logic            user_q;
  logic [1:0]      acc_q;
  logic [PA_W-1:0] base_q;
  logic            res_ok_q, res_r_q, res_w_q, res_x_q;
  logic [2:0]      res_code_q;
  logic [PA_W-1:0] res_pa_q;

  logic            canon, super_hit;
  logic            dir_valid, dir_kread;
  logic [PA_W-1:0] dir_next;
  logic            leaf_fault, leaf_r, leaf_w, leaf_x;
  logic [2:0]      leaf_code;
  logic [IDX_W-1:0] idx;

  ptw_va_decode #(.VA_BITS(VA_BITS)) u_dec (
    .va(req_va), .canon(canon), .super_hit(super_hit)
  );

  ptw_dir_check #(.PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) u_dir (
    .pte(mem_rsp_data), .is_valid(dir_valid), .kread_ok(dir_kread), .next_base(dir_next)
  );

  ptw_leaf_perm u_leaf (
    .pte(mem_rsp_data), .user(user_q), .acc(acc_q),
    .fault(leaf_fault), .code(leaf_code), .pr(leaf_r), .pw(leaf_w), .px(leaf_x)
  );

  always_comb begin
    case (lvl_q)
      2'd0:    idx = va_q[PAGE_BITS + 2*IDX_W +: IDX_W];
      2'd1:    idx = va_q[PAGE_BITS + IDX_W +: IDX_W];
      default: idx = va_q[PAGE_BITS +: IDX_W];
    endcase
  end

  assign mem_req_addr  = base_q + {{PAD_W{1'b0}}, idx, 3'b000};
  assign mem_req_valid = (st_q == S_REQ);
  assign req_ready     = (st_q == S_IDLE);
  assign done          = (st_q == S_FIN);
  assign ok            = res_ok_q;
  assign fault_code    = res_code_q;
  assign pa            = res_pa_q;
  assign perm_r        = res_r_q;
  assign perm_w        = res_w_q;
  assign perm_x        = res_x_q;
  assign fault_va      = va_q;
  assign fault_acc     = acc_report(acc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      lvl_q      <= 2'd0;
      va_q       <= '0;
      user_q     <= 1'b0;
      acc_q      <= ACC_RD;
      base_q     <= '0;
      res_ok_q   <= 1'b0;
      res_code_q <= FLT_TNV;
      res_pa_q   <= '0;
      res_r_q    <= 1'b0;
      res_w_q    <= 1'b0;
      res_x_q    <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          va_q     <= req_va;
          user_q   <= req_user;
          acc_q    <= req_acc;
          base_q   <= ptbr;
          lvl_q    <= 2'd0;
          res_ok_q <= 1'b0;
          res_pa_q <= '0;
          res_r_q  <= 1'b0;
          res_w_q  <= 1'b0;
          res_x_q  <= 1'b0;
          if (!canon || (super_hit && req_user)) begin
            res_code_q <= FLT_ACV;
            st_q       <= S_FIN;
          end else if (super_hit) begin
            res_ok_q   <= 1'b1;
            res_code_q <= FLT_TNV;
            res_pa_q   <= PA_W'(req_va[SP_BITS-1:0]);
            res_r_q    <= 1'b1;
            res_w_q    <= 1'b1;
            res_x_q    <= 1'b1;
            st_q       <= S_FIN;
          end else begin
            st_q <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) st_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (lvl_q != LVL_LEAF) begin
            if (!dir_valid) begin
              res_code_q <= FLT_TNV;
              st_q       <= S_FIN;
            end else if (!dir_kread) begin
              res_code_q <= FLT_ACV;
              st_q       <= S_FIN;
            end else begin
              base_q <= dir_next;
              lvl_q  <= lvl_q + 2'd1;
              st_q   <= S_REQ;
            end
          end else begin
            res_code_q <= leaf_code;
            st_q       <= S_FIN;
            if (!leaf_fault) begin
              res_ok_q <= 1'b1;
              res_pa_q <= PA_W'({mem_rsp_data[63:32], va_q[PAGE_BITS-1:0]});
              res_r_q  <= leaf_r;
              res_w_q  <= leaf_w;
              res_x_q  <= leaf_x;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int VA_BITS = 43,
  parameter int SP_BITS = 40,
  parameter int PA_W    = 45
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [63:0]     req_va,
  input logic [1:0]      req_acc,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            done,
  input logic            ok,
  input logic [2:0]      fault_code,
  input logic [PA_W-1:0] pa,
  input logic            perm_r,
  input logic            perm_w,
  input logic            perm_x,
  input logic [63:0]     fault_va
);
  logic [63:0] cap_va;
  logic [1:0]  cap_acc;
  logic [2:0]  reads;
  logic        cap_super;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_va  <= '0;
      cap_acc <= 2'd0;
      reads   <= 3'd0;
    end else if (req_valid && req_ready) begin
      cap_va  <= req_va;
      cap_acc <= req_acc;
      reads   <= 3'd0;
    end else if (mem_req_valid && mem_req_ready && reads != 3'd7) begin
      reads <= reads + 3'd1;
    end
  end

  assign cap_super = cap_va[63] && (cap_va[VA_BITS-1 -: 2] == 2'b10);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  a_r3_read_limit: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> reads <= 3'd3);
  a_r6_need_rd: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok && cap_acc == 2'd0 |-> perm_r);
  a_r6_need_wr: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok && cap_acc == 2'd1 |-> perm_w);
  a_r6_need_ex: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok && cap_acc == 2'd2 |-> perm_x);
  a_r7_for_match: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ok && fault_code == 3'd2 |-> cap_acc == 2'd0);
  a_r7_foe_match: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ok && fault_code == 3'd3 |-> cap_acc == 2'd2);
  a_r7_fow_match: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ok && fault_code == 3'd4 |-> cap_acc == 2'd1);
  a_r9_probe_codes: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ok && cap_acc == 2'd3 |-> fault_code <= 3'd1);
  a_r2_super_direct: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok && cap_super |-> reads == 3'd0 && pa == PA_W'(cap_va[SP_BITS-1:0]));
  a_r10_fault_addr: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ok |-> fault_va == cap_va && fault_code <= 3'd4);
endmodule

bind ptw_walker ptw_walker_chk #(.VA_BITS(VA_BITS), .SP_BITS(SP_BITS), .PA_W(PA_W)) u_chk (.*);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  localparam int PA_W = 45;
  localparam logic [PA_W-1:0] PTBR = 45'h0A000;
  localparam logic [31:0] L2F = 32'h7;
  localparam logic [31:0] L3F = 32'h9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_user = 1'b0;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = 2'd0;
  logic [PA_W-1:0] ptbr = PTBR;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [PA_W-1:0] mem_req_addr;
  logic [63:0] mem_rsp_data;
  logic done, ok, perm_r, perm_w, perm_x;
  logic [2:0] fault_code;
  logic [PA_W-1:0] pa;
  logic [63:0] fault_va;
  logic [1:0] fault_acc;

  always #5 clk = ~clk;

  ptw_walker dut (.*);

  int checks = 0, errors = 0, reads = 0;
  bit bp = 0, finished = 0, pend = 0;
  logic [PA_W-1:0] paddr;
  logic [PA_W-1:0] alog [4];
  logic [63:0] mem [logic [PA_W-1:0]];

  // result capture
  logic r_ok, r_r, r_w, r_x;
  logic [2:0] r_code;
  logic [PA_W-1:0] r_pa;
  logic [63:0] r_fva;
  logic [1:0] r_facc;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Memory responder: one beat, one cycle after each accepted read
  initial begin
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(paddr) ? mem[paddr] : 64'h0;
        pend = 0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      mem_req_ready = bp ? ~mem_req_ready : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        pend  = 1;
        paddr = mem_req_addr;
        if (reads < 4) alog[reads] = mem_req_addr;
        reads++;
      end
    end
  end

  function automatic logic [63:0] mkva(input logic [9:0] i1, input logic [9:0] i2,
                                       input logic [9:0] i3, input logic [12:0] off);
    return (64'(i1) << 33) | (64'(i2) << 23) | (64'(i3) << 13) | 64'(off);
  endfunction

  localparam logic [63:0] WVA = (64'd5 << 33) | (64'h3FF << 23) | (64'd1 << 13) | 64'hABC;

  task automatic build(input logic [15:0] f1, input logic [15:0] f2,
                       input logic [15:0] f3, input logic [31:0] leaf);
    mem.delete();
    mem[PTBR + 45'(10'd5 * 8)]                       = {L2F, 16'h0, f1};
    mem[(45'(L2F) << 13) + 45'(10'h3FF * 8)]         = {L3F, 16'h0, f2};
    mem[(45'(L3F) << 13) + 45'(10'd1 * 8)]           = {leaf, 16'h0, f3};
  endtask

  task automatic xlate(input logic [63:0] va, input logic user, input logic [1:0] acc);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    reads = 0;
    req_valid = 1'b1; req_va = va; req_user = user; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11: no done pulse, got 0 expected 1");
    end
    r_ok = ok; r_code = fault_code; r_pa = pa; r_r = perm_r; r_w = perm_w; r_x = perm_x;
    r_fva = fault_va; r_facc = fault_acc;
    @(negedge clk);
    check("R11 done single cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    check("R11 reset ready", 64'(req_ready), 64'd1);
    check("R11 reset done", 64'(done), 64'd0);
    check("R11 reset memreq", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_kernel_read;
    build(16'h0101, 16'h0101, 16'h1101, 32'h12345);
    xlate(WVA, 1'b0, 2'd0);
    check("R8 ok", 64'(r_ok), 64'd1);
    check("R8 pa", 64'(r_pa), 64'({32'h12345, 13'hABC}));
    check("R6 perms rwx", 64'({r_r, r_w, r_x}), 64'b111);
    check("R3 reads", 64'(reads), 64'd3);
    check("R3 addr l1", 64'(alog[0]), 64'(PTBR + 45'd40));
    check("R3 addr l2", 64'(alog[1]), 64'((45'(L2F) << 13) + 45'(10'h3FF * 8)));
    check("R3 addr l3", 64'(alog[2]), 64'((45'(L3F) << 13) + 45'd8));
  endtask

  task automatic t_user_bp;
    build(16'h0101, 16'h0101, 16'h2101, 32'h00777);
    bp = 1;
    xlate(WVA, 1'b1, 2'd1);
    check("R6 user write ok", 64'(r_ok), 64'd1);
    check("R6 user perms", 64'({r_r, r_w, r_x}), 64'b010);
    check("R8 pa bp", 64'(r_pa), 64'({32'h00777, 13'hABC}));
    xlate(WVA, 1'b1, 2'd0);
    bp = 0;
    check("R6 user read acv", 64'({r_ok, r_code}), 64'({1'b0, 3'd1}));
    check("R10 acc read", 64'(r_facc), 64'b00);
    check("R10 fault va", r_fva, WVA);
  endtask

  task automatic t_fault_on;
    build(16'h0101, 16'h0101, 16'h110F, 32'h1);
    xlate(WVA, 1'b0, 2'd0);
    check("R7 for", 64'({r_ok, r_code}), 64'({1'b0, 3'd2}));
    xlate(WVA, 1'b0, 2'd1);
    check("R7 fow", 64'({r_ok, r_code}), 64'({1'b0, 3'd4}));
    check("R10 acc write", 64'(r_facc), 64'b01);
    xlate(WVA, 1'b0, 2'd2);
    check("R7 foe", 64'({r_ok, r_code}), 64'({1'b0, 3'd3}));
    check("R10 acc exec", 64'(r_facc), 64'b11);
    build(16'h0101, 16'h0101, 16'h1105, 32'h1);
    xlate(WVA, 1'b0, 2'd0);
    check("R7 masked perms", 64'({r_ok, r_r, r_w, r_x}), 64'b1101);
    build(16'h0101, 16'h0101, 16'h0109, 32'h1);
    xlate(WVA, 1'b0, 2'd1);
    check("R6 acv before fo", 64'({r_ok, r_code}), 64'({1'b0, 3'd1}));
  endtask

  task automatic t_dir;
    build(16'h0100, 16'h0101, 16'h1101, 32'h1);
    xlate(WVA, 1'b0, 2'd0);
    check("R4 l1 tnv", 64'({r_ok, r_code}), 64'({1'b0, 3'd0}));
    check("R4 l1 stop", 64'(reads), 64'd1);
    build(16'h0001, 16'h0101, 16'h1101, 32'h1);
    xlate(WVA, 1'b0, 2'd0);
    check("R4 l1 acv", 64'({r_ok, r_code, 32'(reads)}), 64'({1'b0, 3'd1, 32'd1}));
    build(16'h0101, 16'h0001, 16'h1101, 32'h1);
    xlate(WVA, 1'b0, 2'd0);
    check("R4 l2 acv", 64'({r_ok, r_code, 32'(reads)}), 64'({1'b0, 3'd1, 32'd2}));
    build(16'h0101, 16'h0100, 16'h1101, 32'h1);
    xlate(WVA, 1'b0, 2'd0);
    check("R4 l2 tnv", 64'({r_ok, r_code, 32'(reads)}), 64'({1'b0, 3'd0, 32'd2}));
    build(16'h0101, 16'h0101, 16'h1100, 32'h1);
    xlate(WVA, 1'b0, 2'd2);
    check("R5 leaf tnv", 64'({r_ok, r_code, 32'(reads)}), 64'({1'b0, 3'd0, 32'd3}));
  endtask

  task automatic t_super;
    xlate(64'hFFFF_FC12_3456_789A, 1'b0, 2'd2);
    check("R2 kernel ok", 64'(r_ok), 64'd1);
    check("R2 pa", 64'(r_pa), 64'h12_3456_789A);
    check("R2 perms", 64'({r_r, r_w, r_x}), 64'b111);
    check("R2 no reads", 64'(reads), 64'd0);
    xlate(64'hFFFF_FC12_3456_789A, 1'b1, 2'd0);
    check("R2 user acv", 64'({r_ok, r_code, 32'(reads)}), 64'({1'b0, 3'd1, 32'd0}));
  endtask

  task automatic t_noncanon;
    xlate(64'h0000_0800_0000_1000, 1'b0, 2'd1);
    check("R1 acv", 64'({r_ok, r_code, 32'(reads)}), 64'({1'b0, 3'd1, 32'd0}));
    check("R10 fault va nc", r_fva, 64'h0000_0800_0000_1000);
    check("R10 acc write nc", 64'(r_facc), 64'b01);
  endtask

  task automatic t_probe;
    build(16'h0101, 16'h0101, 16'h110F, 32'h55);
    xlate(WVA, 1'b0, 2'd3);
    check("R9 probe ok", 64'(r_ok), 64'd1);
    check("R9 probe perms", 64'({r_r, r_w, r_x}), 64'b000);
    build(16'h0101, 16'h0101, 16'h0000, 32'h55);
    xlate(mkva(10'd5, 10'h3FF, 10'd1, 13'd0), 1'b1, 2'd3);
    check("R9 probe tnv", 64'({r_ok, r_code}), 64'({1'b0, 3'd0}));
    check("R10 acc probe", 64'(r_facc), 64'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_kernel_read();
    t_user_bp();
    t_fault_on();
    t_dir();
    t_super();
    t_noncanon();
    t_probe();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule